// File: doc/BRIEF.md
# DRAM Read Cycle Sequencer

This block runs read accesses from the controller side to an external DRAM that has a 16-bit data path. An internal client presents a byte address and an access size. The sequencer places the row part and then the column part of that address on one shared address bus. It drives the row strobe, the column strobe and the write-enable pins, and it captures the returned half-word. Every DRAM cycle is a fixed sequence of five clock phases, Q1 to Q5.

A 32-bit read is done as two such cycles. The half-word on the upper side is read first, and the results of the two cycles are joined into one word. A 16-bit read takes a single cycle, and its result is zero-extended. A 4-bit page-size setting decides where the row and column parts of the address separate. A mode input decides how three strobe pins are shared. In one mode they are one CAS and two write enables. In the other they are two CAS pins and one write enable.

Top module: `dram_rd_seq`

## Requirements
- R1: After a synchronous reset the block is idle. cs_n, rd_n, ras_n, strb_a_n, strb_b_n and strb_c_n are all 1, and rsp_valid is 0.
- R2: A request with req_valid=1 is accepted at a clock edge while the block is idle. Phase Q1 fills the next cycle, and each phase lasts one cycle. rsp_valid is a one-cycle pulse. It comes 6 cycles after the accepting edge for a half-word and 11 cycles after it for a word.
- R3: cs_n and rd_n are 0 in every phase of an access, across both halves of a word access. They are 1 while the block is idle.
- R4: mem_addr carries the row address during Q2 and Q3 and the column address during Q4 and Q5. Its value in Q1 is not specified.
- R5: Let hw be the half-word index (byte address >> 1) and let cb = 8 + page. The column is hw mod 2^cb and the row is hw >> cb. Both are cut to the low 16 bits.
- R6: ras_n is 0 in Q2 to Q5 and 1 in Q1, so it rises between the two halves of a word access. The CAS strobe is 0 in Q4 and Q5 only.
- R7: With cfg_dual_cas=0, strb_a_n is the CAS strobe and strb_b_n and strb_c_n (the two write enables) stay 1. With cfg_dual_cas=1, strb_a_n and strb_b_n (low and high CAS) both carry the CAS strobe and strb_c_n (write enable) stays 1.
- R8: Read data is taken from mem_dq at the clock edge that ends Q5, which is when CAS rises. Values present in Q4 or earlier are not used.
- R9: For a word access (req_word=1), address bits 1:0 are ignored. The first cycle reads the even half-word index into rsp_data[31:16], and the second reads the next index into rsp_data[15:0]. For a half-word access (req_word=0), bit 0 is ignored and rsp_data = {16'h0, half-word}.
- R10: While an access is in progress, req_valid, req_addr, req_word, cfg_dual_cas and cfg_page have no effect. Size, mode and page are taken at the accepting edge.
- R11: A request present in the cycle where rsp_valid is 1 is accepted at the end of that cycle, and the next Q1 follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request |
| req_addr | input | 25 | Byte address |
| req_word | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| cfg_dual_cas | input | 1 | 0 = one CAS, two write enables; 1 = two CAS, one write enable |
| cfg_page | input | 4 | Page size; column width = 8 + value |
| mem_addr | output | 16 | Multiplexed row/column address |
| mem_dq | input | 16 | Read data from upper data lines |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| strb_a_n | output | 1 | CAS, or low CAS in dual mode |
| strb_b_n | output | 1 | Low write enable, or high CAS in dual mode |
| strb_c_n | output | 1 | High write enable, or the single write enable in dual mode |
| rsp_valid | output | 1 | Read result valid, one-cycle pulse |
| rsp_data | output | 32 | Read result |

## Verification
The end of one access and the start of the next can fall in the same cycle. The result pulse comes out while a new request is being accepted, and that acceptance must neither upset the result nor delay the next Q1. The bench chains accesses by raising the next request exactly in the cycle of the result pulse. It checks the old result value, and it checks that Q1 of the new access appears in the following cycle with the new address split. Throughout each access the bench also drives a decoy request with opposite size, mode and page, and it puts wrong data on the bus outside Q5. Any leak from the decoy or any early sample shows up in the assembled word.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_Q1   = 3'd1,
        PH_Q2   = 3'd2,
        PH_Q3   = 3'd3,
        PH_Q4   = 3'd4,
        PH_Q5   = 3'd5
    } phase_e;

    typedef struct packed {
        logic       word;
        logic       dual;
        logic [3:0] page;
    } acc_cfg_t;

    // width of the column field in half-word index bits
    function automatic logic [5:0] col_width(input logic [3:0] page, input int base);
        return 6'(base) + 6'(page);
    endfunction

    function automatic logic row_phase(input phase_e ph);
        return (ph == PH_Q2) || (ph == PH_Q3);
    endfunction

    function automatic logic col_phase(input phase_e ph);
        return (ph == PH_Q4) || (ph == PH_Q5);
    endfunction

endpackage

// File: rtl/dram_rd_phase.sv
module dram_rd_phase
    import dram_rd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   word,
    output logic   accept,
    output phase_e phase,
    output logic   second
);
    phase_e ph_q, ph_d;
    logic   sec_q, sec_d;

    assign accept = (ph_q == PH_IDLE) && req_valid;

    always_comb begin
        ph_d  = ph_q;
        sec_d = sec_q;
        unique case (ph_q)
            PH_IDLE: if (req_valid) begin
                ph_d  = PH_Q1;
                sec_d = 1'b0;
            end
            PH_Q1: ph_d = PH_Q2;
            PH_Q2: ph_d = PH_Q3;
            PH_Q3: ph_d = PH_Q4;
            PH_Q4: ph_d = PH_Q5;
            PH_Q5: begin
                if (word && !sec_q) begin
                    ph_d  = PH_Q1;
                    sec_d = 1'b1;
                end else begin
                    ph_d  = PH_IDLE;
                    sec_d = 1'b0;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            sec_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            sec_q <= sec_d;
        end
    end

    assign phase  = ph_q;
    assign second = sec_q;

    // R2: a phase other than idle always advances, never holds
    assert_phase_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE) |=> (ph_q != $past(ph_q)));

endmodule

// File: rtl/dram_rd_addr.sv
module dram_rd_addr
    import dram_rd_pkg::*;
#(
    parameter int ADDR_W   = 25,
    parameter int MA_W     = 16,
    parameter int PAGE_W   = 4,
    parameter int COL_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              second,
    input  logic              word,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    output logic [MA_W-1:0]   mem_addr
);
    localparam int HW_W = ADDR_W - 1;

    logic [HW_W-1:0] hw_base, hw, col_mask, row_f, col_f;
    logic [5:0]      cb;

    always_comb begin
        hw_base  = HW_W'(addr >> 1);
        hw       = word ? {hw_base[HW_W-1:1], second} : hw_base;
        cb       = col_width(4'(page), COL_BASE);
        col_mask = ~({HW_W{1'b1}} << cb);
        col_f    = hw & col_mask;
        row_f    = hw >> cb;
        if (row_phase(phase))
            mem_addr = MA_W'(row_f);
        else if (col_phase(phase))
            mem_addr = MA_W'(col_f);
        else
            mem_addr = '0;
    end

    // R4: the row address is held for both row phases
    assert_row_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_Q3) |-> $stable(mem_addr));

    // R4: the column address is held for both column phases
    assert_col_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_Q5) |-> $stable(mem_addr));

endmodule

// File: rtl/dram_rd_strobe.sv
module dram_rd_strobe
    import dram_rd_pkg::*;
(
    input  phase_e phase,
    input  logic   dual,
    output logic   cs_n,
    output logic   rd_n,
    output logic   ras_n,
    output logic   strb_a_n,
    output logic   strb_b_n,
    output logic   strb_c_n
);
    logic active, ras_on, cas_on;

    always_comb begin
        active   = (phase != PH_IDLE);
        ras_on   = row_phase(phase) || col_phase(phase);
        cas_on   = col_phase(phase);
        cs_n     = !active;
        rd_n     = !active;
        ras_n    = !ras_on;
        strb_a_n = !cas_on;
        // shared pin: low write enable, or high CAS
        strb_b_n = dual ? !cas_on : 1'b1;
        // shared pin: high write enable, or single write enable
        strb_c_n = 1'b1;
    end

endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
    parameter int DQ_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              word,
    input  logic              second,
    input  logic [DQ_W-1:0]   mem_dq,
    output logic              rsp_valid,
    output logic [2*DQ_W-1:0] rsp_data
);
    logic [DQ_W-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (cap) begin
                if (word && !second) begin
                    upper_q <= mem_dq;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= word ? {upper_q, mem_dq} : {{DQ_W{1'b0}}, mem_dq};
                end
            end
        end
    end

    // R2: the result is a single-cycle pulse
    assert_rsp_single_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq
    import dram_rd_pkg::*;
#(
    parameter int ADDR_W   = 25,
    parameter int MA_W     = 16,
    parameter int DQ_W     = 16,
    parameter int PAGE_W   = 4,
    parameter int COL_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              cfg_dual_cas,
    input  logic [PAGE_W-1:0] cfg_page,
    output logic [MA_W-1:0]   mem_addr,
    input  logic [DQ_W-1:0]   mem_dq,
    output logic              cs_n,
    output logic              rd_n,
    output logic              ras_n,
    output logic              strb_a_n,
    output logic              strb_b_n,
    output logic              strb_c_n,
    output logic              rsp_valid,
    output logic [2*DQ_W-1:0] rsp_data
);
    phase_e            phase;
    logic              second, accept;
    logic [ADDR_W-1:0] addr_q;
    acc_cfg_t          cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cfg_q  <= '0;
        end else if (accept) begin
            addr_q     <= req_addr;
            cfg_q.word <= req_word;
            cfg_q.dual <= cfg_dual_cas;
            cfg_q.page <= 4'(cfg_page);
        end
    end

    dram_rd_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .word     (cfg_q.word),
        .accept   (accept),
        .phase    (phase),
        .second   (second)
    );

    dram_rd_addr #(
        .ADDR_W  (ADDR_W),
        .MA_W    (MA_W),
        .PAGE_W  (4),
        .COL_BASE(COL_BASE)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .second  (second),
        .word    (cfg_q.word),
        .page    (cfg_q.page),
        .addr    (addr_q),
        .mem_addr(mem_addr)
    );

    dram_rd_strobe u_strobe (
        .phase   (phase),
        .dual    (cfg_q.dual),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .ras_n   (ras_n),
        .strb_a_n(strb_a_n),
        .strb_b_n(strb_b_n),
        .strb_c_n(strb_c_n)
    );

    dram_rd_capture #(.DQ_W(DQ_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap      (phase == PH_Q5),
        .word     (cfg_q.word),
        .second   (second),
        .mem_dq   (mem_dq),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    // R6: CAS is only ever low inside an open row
    assert_cas_inside_ras_R6: assert property (@(posedge clk) disable iff (rst)
        !strb_a_n |-> !ras_n);

    // R6: the row strobe falls only after a Q1 with chip select already low
    assert_ras_fall_after_q1_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> !$past(cs_n));

    // R3: an open row implies chip select and read strobe
    assert_cs_covers_ras_R3: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (!cs_n && !rd_n));

    // R7: the single write-enable pin never pulses during a read
    assert_we_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> strb_c_n);

endmodule

// File: tb/tb_dram_rd_seq.sv
module tb_dram_rd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        cfg_dual_cas = 1'b0;
    logic [3:0]  cfg_page = '0;
    logic [15:0] mem_addr;
    logic [15:0] mem_dq = '0;
    logic        cs_n, rd_n, ras_n, strb_a_n, strb_b_n, strb_c_n, rsp_valid;
    logic [31:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [24:0] nx_addr;
    logic        nx_word, nx_mode;
    int          nx_page;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_rd_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .cfg_dual_cas(cfg_dual_cas), .cfg_page(cfg_page),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .cs_n(cs_n), .rd_n(rd_n),
        .ras_n(ras_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
        .strb_c_n(strb_c_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int hw);
        return 16'(hw ^ (hw >> 8)) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] exp_row(input int hw, input int p);
        return 16'(hw >> (8 + p));
    endfunction

    function automatic logic [15:0] exp_col(input int hw, input int p);
        return 16'(hw & ((1 << (8 + p)) - 1));
    endfunction

    task automatic do_read(input logic [24:0] a, input bit w, input bit m, input int p,
                           input bit pre, input bit chain);
        int hw0, hw1, n;
        logic [31:0] exp_d;
        if (!pre) begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = a; req_word = w;
            cfg_dual_cas = m; cfg_page = 4'(p);
        end
        hw0 = w ? int'(a >> 2) * 2 : int'(a >> 1);
        hw1 = hw0 + 1;
        n   = w ? 10 : 5;
        exp_d = w ? {pat(hw0), pat(hw1)} : {16'h0, pat(hw0)};
        @(posedge clk);
        for (int k = 1; k <= n; k++) begin
            int q, hw;
            logic [6:0] pins, epins;
            @(negedge clk);
            q  = (k - 1) % 5 + 1;
            hw = (k > 5) ? hw1 : hw0;
            // R10: decoy request with opposite settings during the access
            req_valid = 1'b1; req_addr = ~a; req_word = ~w;
            cfg_dual_cas = ~m; cfg_page = ~4'(p);
            // R8: correct data only in Q5
            mem_dq = (q == 5) ? pat(hw) : (16'h5A5A ^ 16'(k));
            pins  = {cs_n, rd_n, ras_n, strb_a_n, strb_b_n, strb_c_n, rsp_valid};
            epins = {1'b0, 1'b0, (q == 1), (q < 4), (m ? (q < 4) : 1'b1), 1'b1, 1'b0};
            check(pins == epins, "R3/R6/R7 strobes", pins, epins);
            if (q == 2 || q == 3)
                check(mem_addr == exp_row(hw, p), "R4/R5 row", mem_addr, exp_row(hw, p));
            if (q >= 4)
                check(mem_addr == exp_col(hw, p), "R4/R5 col", mem_addr, exp_col(hw, p));
        end
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 rsp timing", rsp_valid, 1);
        check(rsp_data == exp_d, "R8/R9/R10 rsp data", rsp_data, exp_d);
        if (chain) begin
            req_valid = 1'b1; req_addr = nx_addr; req_word = nx_word;
            cfg_dual_cas = nx_mode; cfg_page = 4'(nx_page);
        end else begin
            req_valid = 1'b0;
            @(negedge clk);
            check(!rsp_valid && cs_n && rd_n && ras_n, "R2/R3 idle after rsp",
                  {rsp_valid, cs_n, rd_n, ras_n}, 4'b0111);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [24:0] addrs [5];
        int pages [5];
        addrs[0] = 25'h0000000; addrs[1] = 25'h1FFFFFF; addrs[2] = 25'h0ABCDE6;
        addrs[3] = 25'h1234567; addrs[4] = 25'h15555AB;
        pages[0] = 0; pages[1] = 1; pages[2] = 3; pages[3] = 7; pages[4] = 15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs under reset
        check({cs_n, rd_n, ras_n, strb_a_n, strb_b_n, strb_c_n, rsp_valid} == 7'b1111110,
              "R1 reset state", {cs_n, rd_n, ras_n, strb_a_n, strb_b_n, strb_c_n, rsp_valid},
              7'b1111110);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && ras_n && !rsp_valid, "R1 idle after reset",
              {cs_n, ras_n, rsp_valid}, 3'b110);

        for (int m = 0; m < 2; m++)
            for (int pi = 0; pi < 5; pi++)
                for (int w = 0; w < 2; w++)
                    for (int ai = 0; ai < 5; ai++)
                        do_read(addrs[ai], w[0], m[0], pages[pi], 1'b0, 1'b0);

        // R11: back-to-back chain, next request raised in the result cycle
        nx_addr = 25'h0F0F0F2; nx_word = 1'b0; nx_mode = 1'b1; nx_page = 2;
        do_read(25'h1357ACE, 1'b1, 1'b0, 5, 1'b0, 1'b1);
        nx_addr = 25'h00A5A54; nx_word = 1'b1; nx_mode = 1'b0; nx_page = 9;
        do_read(25'h0F0F0F2, 1'b0, 1'b1, 2, 1'b1, 1'b1);
        do_read(25'h00A5A54, 1'b1, 1'b0, 9, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule